// File: doc/BRIEF.md
# Lookup-Table Brightness Ramp Sequencer

This block plays brightness patterns for a set of LED channels. A shared table holds brightness values. Each channel has its own small engine that walks a window of that table, from a programmed lower index to a programmed upper index. The engine moves one entry per step, and a step lasts a programmed number of 1 ms ticks. The entry being shown appears on the channel's duty output, which feeds a separate PWM generator.

The pattern mode of each channel sets five options:
- the direction of travel;
- whether the run repeats;
- bounce playback, which turns around at the far end instead of wrapping;
- an optional dwell at the upper end;
- an optional dwell at the lower end.

Each dwell is a count of whole steps. A single start strobe carries one bit per channel, so several channels can begin their patterns on the same clock edge.

Each channel also has a source selector. It chooses between the table-driven value, a fixed level value, or zero. Software loads the table and the per-channel registers through a simple write port, then starts the channels with the start strobe.

Top module: `ramp_sequencer`

## Requirements
- R1: A write to the table stores the value at the given index. While a channel selects the ramp source, its duty output equals the table entry at the channel's current index, and a table write to that index shows on the duty output in the next cycle.
- R2: Field 6 is the source selector. Bit 1 set selects the table value. Otherwise bit 2 set selects the level register (field 7). Otherwise the duty output is 0.
- R3: Field 3 is the step length, in ticks. Each table entry is held for exactly that many ticks, and a step length of 0 behaves as 1. Without a tick, a start or a write, the duty output of a running channel does not change.
- R4: Mode bit 4 set starts at the lower index and walks upward; clear starts at the upper index and walks downward. With mode bit 3 (repeat) set and bit 2 clear, the index jumps back to the start entry after the far end.
- R5: With repeat clear, the run stops after the dwell on the final entry ends. The channel then shows the final entry, clears busy and raises done. Done stays high until the channel is started again, and done and busy are never high together.
- R6: With mode bit 2 (bounce) set, the engine turns at the far end without repeating that entry and walks back to the start end. One pass is out and back. With repeat set, bounce continues indefinitely.
- R7: When mode bit 1 is set, the upper-end entry is held for 1 + field 4 steps. When mode bit 0 is set, the lower-end entry is held for 1 + field 5 steps. When a bit is clear, its count has no effect.
- R8: When the lower index (field 1) equals the upper index (field 2), the engine walks the whole table, from 0 to DEPTH-1.
- R9: A start strobe restarts every channel whose mask bit is set, on the same edge. Each such channel goes to its start entry with its step counters cleared. A tick in the same cycle is ignored by those channels, and channels whose bit is clear are not affected.
- R10: After reset, all registers and the table are zero, busy and done are low, and the duty outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 1 ms |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | IW (6) | Table write index |
| lut_data | input | DW (9) | Table write value |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_chan | input | CSW (1) | Channel being written |
| cfg_sel | input | 3 | Field: 0 mode, 1 lower index, 2 upper index, 3 step length, 4 upper dwell, 5 lower dwell, 6 source, 7 level |
| cfg_data | input | CFG_W (9) | Field value, right-aligned |
| start_we | input | 1 | Start strobe |
| start_mask | input | NCH (2) | One bit per channel to start |
| duty | output | NCH*DW (18) | Duty value per channel, channel 0 in the low bits |
| busy | output | NCH (2) | Channel pattern is running |
| done | output | NCH (2) | One-shot run finished |

## Verification
Two events can fall on the same clock edge: a start strobe and the tick that would advance a running channel. The bench runs a channel a few entries into its pattern, then raises start and tick together. It expects the channel to show its start entry, not the next one, and to move only one entry on the following tick. Channels left out of the start mask must keep advancing through that cycle. The bench checks this against a second channel that runs a different pattern.

// File: rtl/ramp_seq_pkg.sv
// Shared types for the ramp sequencer: register field codes and mode bits.
package ramp_seq_pkg;

    // Field codes for the per-channel register write port.
    typedef enum logic [2:0] {
        FLD_MODE     = 3'd0,
        FLD_LO       = 3'd1,
        FLD_HI       = 3'd2,
        FLD_STEP     = 3'd3,
        FLD_HI_DWELL = 3'd4,
        FLD_LO_DWELL = 3'd5,
        FLD_SRC      = 3'd6,
        FLD_LEVEL    = 3'd7
    } field_e;

    // Pattern mode, packed in the bit order of the mode field (bit4 .. bit0).
    typedef struct packed {
        logic up;          // bit4: start at lower index, walk upward
        logic rep;         // bit3: repeat
        logic bounce;      // bit2: turn around at the far end
        logic hold_hi_en;  // bit1: dwell on upper entry
        logic hold_lo_en;  // bit0: dwell on lower entry
    } mode_t;

endpackage

// File: rtl/ramp_lut.sv
// Shared brightness table with one write port and one combinational read
// port per channel. Assumes writes and reads are in the same clock domain.
module ramp_lut #(
    parameter int DEPTH = 64,
    parameter int DW    = 9,
    parameter int NCH   = 2,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH*IW-1:0] rd_idx,
    output logic [NCH*DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Table storage: cleared on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_rd
        // Read port for channel g.
        assign rd_data[g*DW +: DW] = mem[rd_idx[g*IW +: IW]];
    end
endmodule

// File: rtl/ramp_chan_regs.sv
// Per-channel configuration registers, written one field at a time.
// Assumes the write data is right-aligned and wide enough for every field.
module ramp_chan_regs
    import ramp_seq_pkg::*;
#(
    parameter int IW      = 6,
    parameter int DW      = 9,
    parameter int STEP_W  = 9,
    parameter int PAUSE_W = 8,
    parameter int CFG_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  field_e             sel,
    input  logic [CFG_W-1:0]   wdata,
    output mode_t              mode,
    output logic [IW-1:0]      lo,
    output logic [IW-1:0]      hi,
    output logic [STEP_W-1:0]  step_len,
    output logic [PAUSE_W-1:0] hi_dwell,
    output logic [PAUSE_W-1:0] lo_dwell,
    output logic               src_ramp,
    output logic               src_level,
    output logic [DW-1:0]      level
);
    // Field write decode and storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            lo        <= '0;
            hi        <= '0;
            step_len  <= '0;
            hi_dwell  <= '0;
            lo_dwell  <= '0;
            src_ramp  <= 1'b0;
            src_level <= 1'b0;
            level     <= '0;
        end else if (we) begin
            unique case (sel)
                FLD_MODE:     mode     <= mode_t'(wdata[4:0]);
                FLD_LO:       lo       <= wdata[IW-1:0];
                FLD_HI:       hi       <= wdata[IW-1:0];
                FLD_STEP:     step_len <= wdata[STEP_W-1:0];
                FLD_HI_DWELL: hi_dwell <= wdata[PAUSE_W-1:0];
                FLD_LO_DWELL: lo_dwell <= wdata[PAUSE_W-1:0];
                FLD_SRC: begin
                    src_ramp  <= wdata[1];
                    src_level <= wdata[2];
                end
                FLD_LEVEL:    level    <= wdata[DW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ramp_engine.sv
// Index sequencer for one channel. It counts ticks into steps and steps into
// entry dwells, then moves the index up, down, wraps, turns or stops as the
// mode asks. Assumes lo < hi, or lo == hi to mean the whole table.
module ramp_engine
    import ramp_seq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int STEP_W  = 9,
    parameter int PAUSE_W = 8,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  mode_t              mode,
    input  logic [IW-1:0]      lo,
    input  logic [IW-1:0]      hi,
    input  logic [STEP_W-1:0]  step_len,
    input  logic [PAUSE_W-1:0] hi_dwell,
    input  logic [PAUSE_W-1:0] lo_dwell,
    output logic [IW-1:0]      idx,
    output logic               busy,
    output logic               done
);
    logic [IW-1:0]      idx_q, idx_n, span_lo, span_hi;
    logic               up_q, up_n, turned_q, turned_n, run_q, run_n, done_q, done_n;
    logic [STEP_W-1:0]  tick_cnt;
    logic [PAUSE_W-1:0] step_cnt, extra;
    logic               at_top, at_bot, at_end, step_last, dwell_last;

    // Effective window: equal indexes select the whole table.
    always_comb begin
        span_lo = (lo == hi) ? '0 : lo;
        span_hi = (lo == hi) ? IW'(DEPTH - 1) : hi;
    end

    // End detection, dwell length and counter limits.
    always_comb begin
        at_top     = (idx_q == span_hi);
        at_bot     = (idx_q == span_lo);
        at_end     = up_q ? at_top : at_bot;
        extra      = (at_top && mode.hold_hi_en) ? hi_dwell :
                     (at_bot && mode.hold_lo_en) ? lo_dwell : '0;
        step_last  = (step_len == '0) || (tick_cnt == step_len - 1'b1);
        dwell_last = (step_cnt == extra);
    end

    // Next index and direction once the current dwell ends.
    always_comb begin
        idx_n    = idx_q;
        up_n     = up_q;
        turned_n = turned_q;
        run_n    = run_q;
        done_n   = done_q;
        if (!at_end) begin
            idx_n = up_q ? idx_q + 1'b1 : idx_q - 1'b1;
        end else if (mode.bounce && !turned_q) begin
            up_n     = !up_q;
            turned_n = 1'b1;
            idx_n    = up_q ? idx_q - 1'b1 : idx_q + 1'b1;
        end else if (mode.rep) begin
            if (mode.bounce) begin
                up_n     = !up_q;
                turned_n = 1'b0;
                idx_n    = up_q ? idx_q - 1'b1 : idx_q + 1'b1;
            end else begin
                idx_n = up_q ? span_lo : span_hi;
            end
        end else begin
            run_n  = 1'b0;
            done_n = 1'b1;
        end
    end

    // Sequencer state: start has priority over tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            up_q     <= 1'b0;
            turned_q <= 1'b0;
            run_q    <= 1'b0;
            done_q   <= 1'b0;
            tick_cnt <= '0;
            step_cnt <= '0;
        end else if (start) begin
            idx_q    <= mode.up ? span_lo : span_hi;
            up_q     <= mode.up;
            turned_q <= 1'b0;
            run_q    <= 1'b1;
            done_q   <= 1'b0;
            tick_cnt <= '0;
            step_cnt <= '0;
        end else if (run_q && tick) begin
            if (!step_last) begin
                tick_cnt <= tick_cnt + 1'b1;
            end else begin
                tick_cnt <= '0;
                if (!dwell_last) begin
                    step_cnt <= step_cnt + 1'b1;
                end else begin
                    step_cnt <= '0;
                    idx_q    <= idx_n;
                    up_q     <= up_n;
                    turned_q <= turned_n;
                    run_q    <= run_n;
                    done_q   <= done_n;
                end
            end
        end
    end

    assign idx  = idx_q;
    assign busy = run_q;
    assign done = done_q;
endmodule

// File: rtl/ramp_sequencer.sv
// Top level: shared table, per-channel registers and engines, and the duty
// source select. Assumes tick is a single-cycle pulse in the clk domain.
module ramp_sequencer
    import ramp_seq_pkg::*;
#(
    parameter int NCH     = 2,
    parameter int DEPTH   = 64,
    parameter int DW      = 9,
    parameter int STEP_W  = 9,
    parameter int PAUSE_W = 8,
    localparam int IW     = $clog2(DEPTH),
    localparam int CSW    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW_A   = (STEP_W > DW) ? STEP_W : DW,
    localparam int CW_B   = (CW_A > PAUSE_W) ? CW_A : PAUSE_W,
    localparam int CFG_W  = (CW_B > IW) ? CW_B : IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lut_we,
    input  logic [IW-1:0]     lut_addr,
    input  logic [DW-1:0]     lut_data,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_chan,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              start_we,
    input  logic [NCH-1:0]    start_mask,
    output logic [NCH*DW-1:0] duty,
    output logic [NCH-1:0]    busy,
    output logic [NCH-1:0]    done
);
    logic [NCH*IW-1:0] rd_idx;
    logic [NCH*DW-1:0] rd_data;

    ramp_lut #(.DEPTH(DEPTH), .DW(DW), .NCH(NCH)) u_lut (
        .clk(clk), .rst_n(rst_n), .we(lut_we), .waddr(lut_addr),
        .wdata(lut_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mode_t              mode;
        logic [IW-1:0]      lo, hi;
        logic [STEP_W-1:0]  step_len;
        logic [PAUSE_W-1:0] hi_dwell, lo_dwell;
        logic               src_ramp, src_level;
        logic [DW-1:0]      level;
        logic               sel_me;

        // Register write steering for this channel.
        assign sel_me = cfg_we && (cfg_chan == CSW'(g));

        ramp_chan_regs #(
            .IW(IW), .DW(DW), .STEP_W(STEP_W), .PAUSE_W(PAUSE_W), .CFG_W(CFG_W)
        ) u_regs (
            .clk(clk), .rst_n(rst_n), .we(sel_me), .sel(field_e'(cfg_sel)),
            .wdata(cfg_data), .mode(mode), .lo(lo), .hi(hi),
            .step_len(step_len), .hi_dwell(hi_dwell), .lo_dwell(lo_dwell),
            .src_ramp(src_ramp), .src_level(src_level), .level(level)
        );

        ramp_engine #(.DEPTH(DEPTH), .STEP_W(STEP_W), .PAUSE_W(PAUSE_W)) u_eng (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .start(start_we && start_mask[g]), .mode(mode), .lo(lo), .hi(hi),
            .step_len(step_len), .hi_dwell(hi_dwell), .lo_dwell(lo_dwell),
            .idx(rd_idx[g*IW +: IW]), .busy(busy[g]), .done(done[g])
        );

        // Duty source select: ramp first, then fixed level, else zero.
        assign duty[g*DW +: DW] = src_ramp  ? rd_data[g*DW +: DW] :
                                  src_level ? level : '0;
    end
endmodule

// File: rtl/ramp_sequencer_chk.sv
// Property checker for the ramp sequencer, attached with bind below.
module ramp_sequencer_chk #(
    parameter int NCH = 2,
    parameter int DW  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              lut_we,
    input logic              cfg_we,
    input logic              start_we,
    input logic [NCH-1:0]    start_mask,
    input logic [NCH*DW-1:0] duty,
    input logic [NCH-1:0]    busy,
    input logic [NCH-1:0]    done
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_start_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (start_we && start_mask[g]) |=> (busy[g] && !done[g]));

        assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (done[g] && !(start_we && start_mask[g])) |=> done[g]);

        assert_done_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done[g]) |-> $past(tick));

        assert_done_excl_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(done[g] && busy[g]));

        assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[g] && !tick && !start_we && !cfg_we && !lut_we)
            |=> $stable(duty[g*DW +: DW]));
    end
endmodule

bind ramp_sequencer ramp_sequencer_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lut_we(lut_we), .cfg_we(cfg_we),
    .start_we(start_we), .start_mask(start_mask), .duty(duty),
    .busy(busy), .done(done)
);

// File: tb/ramp_sequencer_tb.sv
// Self-checking bench: sweeps modes over small windows of a 64-entry table.
module ramp_sequencer_tb;
    localparam int NCH = 2, DW = 9, IW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              lut_we = 1'b0;
    logic [IW-1:0]     lut_addr = '0;
    logic [DW-1:0]     lut_data = '0;
    logic              cfg_we = 1'b0;
    logic [0:0]        cfg_chan = '0;
    logic [2:0]        cfg_sel = '0;
    logic [8:0]        cfg_data = '0;
    logic              start_we = 1'b0;
    logic [NCH-1:0]    start_mask = '0;
    logic [NCH*DW-1:0] duty;
    logic [NCH-1:0]    busy, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ramp_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lut_we(lut_we),
        .lut_addr(lut_addr), .lut_data(lut_data), .cfg_we(cfg_we),
        .cfg_chan(cfg_chan), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .start_we(start_we), .start_mask(start_mask), .duty(duty),
        .busy(busy), .done(done)
    );

    function automatic int tv(int i);
        return (i * 37 + 5) % 512;
    endfunction

    function automatic int dch(int ch);
        return int'(duty[ch*DW +: DW]);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(int ch, int sel, int val);
        cfg_we = 1'b1; cfg_chan = 1'(ch); cfg_sel = 3'(sel); cfg_data = 9'(val);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic go(int mask);
        start_we = 1'b1; start_mask = NCH'(mask);
        cyc();
        start_we = 1'b0; start_mask = '0;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            cyc();
            tick = 1'b0;
        end
    endtask

    task automatic setup(int ch, int mode, int lo, int hi, int stp, int hp, int lp);
        wr(ch, 0, mode); wr(ch, 1, lo); wr(ch, 2, hi); wr(ch, 3, stp);
        wr(ch, 4, hp); wr(ch, 5, lp); wr(ch, 6, 2);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seqpp[6];
        seqpp = '{2, 3, 4, 5, 4, 3};
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R10 reset state
        chk("R10 duty0", dch(0), 0);
        chk("R10 duty1", dch(1), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);

        // load table
        for (int i = 0; i < 64; i++) begin
            lut_we = 1'b1; lut_addr = IW'(i); lut_data = DW'(tv(i));
            cyc();
        end
        lut_we = 1'b0;

        // R2 source select
        wr(0, 7, 300); wr(0, 6, 4);
        chk("R2 level", dch(0), 300);
        wr(0, 6, 0);
        chk("R2 none", dch(0), 0);
        wr(0, 6, 6);
        chk("R2 ramp wins", dch(0), tv(0));

        // R4 + R5 forward one-shot
        setup(0, 5'h10, 2, 5, 1, 0, 0);
        go(1);
        chk("R4 fwd start", dch(0), tv(2));
        for (int k = 1; k <= 3; k++) begin
            ticks(1);
            chk("R4 fwd step", dch(0), tv(2 + k));
        end
        chk("R5 busy before end", int'(busy[0]), 1);
        ticks(1);
        chk("R5 done raised", int'(done[0]), 1);
        chk("R5 busy cleared", int'(busy[0]), 0);
        chk("R5 holds final", dch(0), tv(5));
        ticks(5);
        chk("R5 still final", dch(0), tv(5));
        chk("R5 done held", int'(done[0]), 1);

        // R4 reverse repeating
        setup(0, 5'h08, 2, 5, 1, 0, 0);
        go(1);
        chk("R5 done cleared by start", int'(done[0]), 0);
        chk("R4 rev start", dch(0), tv(5));
        for (int k = 1; k <= 9; k++) begin
            ticks(1);
            chk("R4 rev wrap", dch(0), tv(5 - (k % 4)));
        end

        // R6 bounce repeating
        setup(0, 5'h1C, 2, 5, 1, 0, 0);
        go(1);
        for (int k = 1; k <= 13; k++) begin
            ticks(1);
            chk("R6 bounce rep", dch(0), tv(seqpp[k % 6]));
        end

        // R6 bounce one-shot
        setup(0, 5'h14, 2, 5, 1, 0, 0);
        go(1);
        ticks(6);
        chk("R6 back at start", dch(0), tv(2));
        chk("R6 not done yet", int'(done[0]), 0);
        ticks(1);
        chk("R6 done after pass", int'(done[0]), 1);
        chk("R6 final entry", dch(0), tv(2));

        // R7 dwells enabled
        setup(0, 5'h1B, 2, 4, 1, 2, 1);
        go(1);
        begin
            int expd[9];
            expd = '{2, 2, 3, 4, 4, 4, 2, 2, 3};
            for (int k = 1; k <= 8; k++) begin
                ticks(1);
                chk("R7 dwell on", dch(0), tv(expd[k]));
            end
        end
        // R7 counts ignored when enables clear
        wr(0, 0, 5'h18);
        go(1);
        for (int k = 1; k <= 6; k++) begin
            ticks(1);
            chk("R7 dwell off", dch(0), tv(2 + (k % 3)));
        end

        // R3 step length 3
        setup(0, 5'h10, 2, 5, 3, 0, 0);
        go(1);
        ticks(2);
        chk("R3 held", dch(0), tv(2));
        ticks(1);
        chk("R3 advance", dch(0), tv(3));
        repeat (4) cyc();
        chk("R3 no tick hold", dch(0), tv(3));
        ticks(8);
        chk("R3 last entry", dch(0), tv(5));
        chk("R3 not done", int'(done[0]), 0);
        ticks(1);
        chk("R3 done", int'(done[0]), 1);
        // R3 step length 0 acts as 1
        wr(0, 3, 0);
        go(1);
        ticks(1);
        chk("R3 zero step", dch(0), tv(3));

        // R8 whole table when indexes equal
        setup(0, 5'h18, 7, 7, 1, 0, 0);
        go(1);
        chk("R8 start 0", dch(0), tv(0));
        ticks(63);
        chk("R8 top", dch(0), tv(63));
        ticks(1);
        chk("R8 wrap", dch(0), tv(0));

        // R1 table write at shown index
        lut_we = 1'b1; lut_addr = 0; lut_data = 9'd444;
        cyc();
        lut_we = 1'b0;
        chk("R1 live write", dch(0), 444);
        lut_we = 1'b1; lut_addr = 0; lut_data = DW'(tv(0));
        cyc();
        lut_we = 1'b0;

        // R9 multi-channel start and start/tick coincidence
        setup(0, 5'h18, 2, 5, 1, 0, 0);
        setup(1, 5'h08, 10, 12, 1, 0, 0);
        go(3);
        chk("R9 ch0 start", dch(0), tv(2));
        chk("R9 ch1 start", dch(1), tv(12));
        chk("R9 both busy", int'(busy), 3);
        ticks(2);
        chk("R9 ch0 run", dch(0), tv(4));
        chk("R9 ch1 run", dch(1), tv(10));
        tick = 1'b1; start_we = 1'b1; start_mask = 2'b01;
        cyc();
        tick = 1'b0; start_we = 1'b0; start_mask = '0;
        chk("R9 start beats tick", dch(0), tv(2));
        chk("R9 unmasked advances", dch(1), tv(12));
        ticks(1);
        chk("R9 one step after", dch(0), tv(3));
        chk("R9 ch1 continues", dch(1), tv(11));

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule